// File: doc/BRIEF.md
# Dual-Port Atomic Exchange Memory

This block is a small word-organised memory shared by two requesters, for instance two processor cores. Each requester can issue a plain read, a plain write, or an atomic exchange. An exchange fetches the addressed location, hands the old contents back to the requester, and stores the requester's new operand in the same place. The other port cannot touch memory between those two halves. Exchanges and plain accesses come in word (32-bit) and byte (8-bit) sizes. Byte addressing is little-endian.

A binary lock is the typical use. A requester exchanges the locked value into a lock word and looks at what came back. If it got the unlocked value, it now owns the lock. To release the lock it does a plain write of the unlocked value. When both ports are waiting, a round-robin pointer picks the winner. The grant is not taken from a port until its whole transaction has finished.

Each port has its own request channel. A requester raises `valid` with its operation fields and must keep all of them steady until `ready` is returned. `ready` is high for exactly one cycle, when the transaction completes, and `rdata` is valid only in that cycle. A requester that wants a second transaction drops or keeps `valid` after that cycle; the block accepts nothing from a port while that port's transaction is still in progress.

Top module: `atomic_swap_mem`

## Requirements
- R1: After reset, both `ready` outputs are low, both `rdata` outputs are zero, and every memory word reads as zero.
- R2: A read (op code 0) returns the addressed word, or for a byte read the lane chosen by addr[1:0] (lane n is bits 8n+7:8n), zero-extended to 32 bits. `ready` is high in the first cycle after the edge that accepts it.
- R3: A write (op code 1) has no read phase and completes in the first cycle after acceptance. A word write replaces all four lanes. A byte write stores wdata[7:0] into lane addr[1:0] only, and the other three lanes keep their contents.
- R4: A word exchange (op code 2) returns the value the word held before the exchange and leaves wdata stored there. `ready` is high in the second cycle after acceptance.
- R5: No access from the other port falls between the read half and the write half of an exchange. Two ports that both spin on exchange-based locking of one word are never inside the guarded section at the same time.
- R6: A byte exchange returns the old byte of lane addr[1:0], zero-extended, and writes wdata[7:0] into that lane only. The other lanes stay unchanged.
- R7: When both ports wait while the block is idle, the port named by the round-robin pointer wins. The pointer is port 0 after reset. When a transaction completes, the pointer moves to the port that did not own it, and it does not move at any other time.
- R8: `ready` is high for exactly one cycle per transaction and is never high on both ports in the same cycle. `rdata` is zero whenever `ready` is low.
- R9: The block relies on three rules for its inputs. Op code 3 is never issued. Word accesses have addr[1:0] = 0. A requester holds every request field stable from raising `valid` until its `ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_valid | input | 1 | Port 0 request pending |
| p0_op | input | 2 | Port 0 operation: 0 read, 1 write, 2 exchange |
| p0_byte | input | 1 | Port 0 size: 1 byte, 0 word |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 store operand (bits 7:0 for byte size) |
| p0_ready | output | 1 | Port 0 transaction completes this cycle |
| p0_rdata | output | 32 | Port 0 returned data, valid with p0_ready |
| p1_valid | input | 1 | Port 1 request pending |
| p1_op | input | 2 | Port 1 operation: 0 read, 1 write, 2 exchange |
| p1_byte | input | 1 | Port 1 size: 1 byte, 0 word |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 store operand (bits 7:0 for byte size) |
| p1_ready | output | 1 | Port 1 transaction completes this cycle |
| p1_rdata | output | 32 | Port 1 returned data, valid with p1_ready |

## Verification
The assertions take the R9 rules for granted. No op code 3 arrives, word addresses are aligned, and a requester keeps its fields frozen while it waits. The random stimulus keeps to these rules by construction. It draws op codes only from 0 to 2 and clears the low address bits for word accesses. Each port is driven by a task that sets the fields once, holds them until `ready`, and only then lowers `valid`. The directed lock-spinning phase follows the same task discipline, so the contention the block sees there stays within those rules.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/swap_rr_arbiter.sv
module swap_rr_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       complete,
  input  logic       owner,
  output logic       win
);
  logic prio;

  always_comb begin
    if (req == 2'b11) win = prio;
    else              win = req[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        prio <= 1'b0;
    else if (complete) prio <= ~owner;
  end

  // R7: after a completion the pointer names the port that did not own it
  assert_prio_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (prio != $past(owner)));

  // R7: without a completion the pointer holds
  assert_prio_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> $stable(prio));
endmodule

// File: rtl/swap_lane_unit.sv
module swap_lane_unit #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [LANE_W-1:0] lane,
  input  logic              byte_op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] extract
);
  logic [7:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = !byte_op || (lane == LANE_W'(g));
    assign merged[g*8 +: 8] = hit ? (byte_op ? wdata[7:0] : wdata[g*8 +: 8])
                                  : cur[g*8 +: 8];
  end

  assign picked  = cur[lane*8 +: 8];
  assign extract = byte_op ? {{(DATA_W-8){1'b0}}, picked} : cur;
endmodule

// File: rtl/swap_store.sv
module swap_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/atomic_swap_mem.sv
module atomic_swap_mem
  import swap_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DATA_W = 32,
  localparam int IDX_W  = ADDR_W - 2,
  localparam int WORDS  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_valid,
  input  logic [1:0]        p0_op,
  input  logic              p0_byte,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic              p0_ready,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_valid,
  input  logic [1:0]        p1_op,
  input  logic              p1_byte,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic              p1_ready,
  output logic [DATA_W-1:0] p1_rdata
);
  logic [1:0]        vld;
  op_e               op_a   [2];
  logic              byte_a [2];
  logic [ADDR_W-1:0] addr_a [2];
  logic [DATA_W-1:0] wdat_a [2];

  assign vld       = {p1_valid, p0_valid};
  assign op_a[0]   = op_e'(p0_op);
  assign op_a[1]   = op_e'(p1_op);
  assign byte_a[0] = p0_byte;
  assign byte_a[1] = p1_byte;
  assign addr_a[0] = p0_addr;
  assign addr_a[1] = p1_addr;
  assign wdat_a[0] = p0_wdata;
  assign wdat_a[1] = p1_wdata;

  phase_e            phase;
  logic              owner;
  logic              win;
  logic [DATA_W-1:0] old_q;
  logic              finish;
  logic              we;
  logic [1:0]        done;
  logic [DATA_W-1:0] resp;

  op_e               sel_op;
  logic              sel_byte;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic [DATA_W-1:0] cur_word, merged, extract;

  assign sel_op    = op_a[owner];
  assign sel_byte  = byte_a[owner];
  assign sel_addr  = addr_a[owner];
  assign sel_wdata = wdat_a[owner];

  swap_rr_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req(vld),
    .complete(finish), .owner(owner), .win(win)
  );

  swap_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(sel_addr[ADDR_W-1:2]),
    .we(we), .wdata(merged), .rdata(cur_word)
  );

  swap_lane_unit #(.DATA_W(DATA_W)) u_lane (
    .cur(cur_word), .lane(sel_addr[1:0]), .byte_op(sel_byte),
    .wdata(sel_wdata), .merged(merged), .extract(extract)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      owner <= 1'b0;
      old_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (|vld) begin
          owner <= win;
          phase <= PH_FIRST;
        end
        PH_FIRST: if (sel_op == OP_SWAP) begin
          old_q <= extract;
          phase <= PH_SECOND;
        end else begin
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign finish = ((phase == PH_FIRST) && (sel_op != OP_SWAP)) || (phase == PH_SECOND);
  assign we     = ((phase == PH_FIRST) && (sel_op == OP_WRITE)) || (phase == PH_SECOND);
  assign resp   = (phase == PH_SECOND) ? old_q :
                  (sel_op == OP_READ)  ? extract : '0;

  for (genvar p = 0; p < 2; p++) begin : g_done
    assign done[p] = finish && (owner == 1'(p));
  end

  assign p0_ready = done[0];
  assign p1_ready = done[1];
  assign p0_rdata = done[0] ? resp : '0;
  assign p1_rdata = done[1] ? resp : '0;

  // R5: the write half directly follows the read half with the same owner
  assert_halves_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SECOND) |-> ($past(phase) == PH_FIRST) && $stable(owner));

  // R5: the exchange targets one location for both halves
  assert_same_location_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SECOND) |-> $stable(sel_addr));

  // R8: never both ports complete together
  assert_ready_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p1_ready, p0_ready}));

  // R8: a completion lasts one cycle
  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ready || p1_ready) |=> !(p0_ready || p1_ready));

  // R9: word accesses are aligned and the op code is legal
  assert_legal_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (sel_op != OP_BAD) && (sel_byte || sel_addr[1:0] == 2'b00));

  // R9: the owner's fields stay frozen while its transaction runs
  assert_fields_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST && !finish) |=> $stable(sel_op) && $stable(sel_wdata) && $stable(sel_byte));
endmodule

// File: tb/atomic_swap_mem_tb.sv
`timescale 1ns/1ps
module atomic_swap_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld  [2];
  logic [1:0]  opv  [2];
  logic        bszv [2];
  logic [7:0]  adrv [2];
  logic [31:0] wdv  [2];
  logic        rdy  [2];
  logic [31:0] rdv  [2];

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [64];
  bit in_cs [2];
  int entries [2];

  always #2 clk = ~clk;

  atomic_swap_mem #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .p0_valid(vld[0]), .p0_op(opv[0]), .p0_byte(bszv[0]), .p0_addr(adrv[0]),
    .p0_wdata(wdv[0]), .p0_ready(rdy[0]), .p0_rdata(rdv[0]),
    .p1_valid(vld[1]), .p1_op(opv[1]), .p1_byte(bszv[1]), .p1_addr(adrv[1]),
    .p1_wdata(wdv[1]), .p1_ready(rdy[1]), .p1_rdata(rdv[1])
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_get(input logic [7:0] a, input logic bsz);
    logic [31:0] w = model[a[7:2]];
    return bsz ? {24'd0, w[a[1:0]*8 +: 8]} : w;
  endfunction

  function automatic void model_put(input logic [7:0] a, input logic bsz, input logic [31:0] d);
    if (bsz) model[a[7:2]][a[1:0]*8 +: 8] = d[7:0];
    else     model[a[7:2]] = d;
  endfunction

  task automatic do_op(input int p, input logic [1:0] op, input logic bsz, input logic [7:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
    logic [31:0] exp;
    vld[p] = 1'b1; opv[p] = op; bszv[p] = bsz; adrv[p] = a; wdv[p] = wd;
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!rdy[p] && lat < 200);
    check(rdy[p], "R8 completion", {31'd0, rdy[p]}, 32'd1);
    rd  = rdv[p];
    exp = model_get(a, bsz);
    if (op == 2'd0) check(rd == exp, bsz ? "R2 byte read" : "R2 word read", rd, exp);
    if (op == 2'd2) check(rd == exp, bsz ? "R6 byte exchange" : "R4 word exchange", rd, exp);
    if (op == 2'd1) check(rd == 32'd0, "R8 rdata on write", rd, 32'd0);
    if (op != 2'd0) model_put(a, bsz, wd);
    vld[p] = 1'b0;
    @(posedge clk); #1;
    check(!rdy[p] && rdv[p] == 32'd0, "R8 single pulse", rdv[p], 32'd0);
  endtask

  task automatic rand_port(input int p, input int n);
    logic [31:0] rd;
    int lat;
    for (int i = 0; i < n; i++) begin
      logic [1:0] op  = 2'($urandom_range(0, 2));
      logic       bsz = 1'($urandom_range(0, 1));
      logic [7:0] a   = 8'($urandom_range(0, 31));
      if (!bsz) a[1:0] = 2'b00;
      do_op(p, op, bsz, a, $urandom, rd, lat);
      repeat ($urandom_range(0, 2)) @(posedge clk);
      #1;
    end
  endtask

  task automatic lock_port(input int p, input int want);
    logic [31:0] rd;
    int lat;
    int tries = 0;
    while (entries[p] < want && tries < 3000) begin
      tries++;
      do_op(p, 2'd2, 1'b0, 8'h80, 32'd1, rd, lat);
      if (rd == 32'd0) begin
        in_cs[p] = 1'b1;
        entries[p]++;
        check(!in_cs[1-p], "R5 mutual exclusion", {31'd0, in_cs[1-p]}, 32'd0);
        do_op(p, 2'd0, 1'b0, 8'h84, 32'd0, rd, lat);
        do_op(p, 2'd1, 1'b0, 8'h84, rd + 32'd1, rd, lat);
        check(!in_cs[1-p], "R5 mutual exclusion", {31'd0, in_cs[1-p]}, 32'd0);
        do_op(p, 2'd1, 1'b0, 8'h80, 32'd0, rd, lat);
        in_cs[p] = 1'b0;
      end
    end
    check(entries[p] == want, "R5 lock progress", entries[p], want);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd1;
    int lat, lat1;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) model[i] = 32'd0;
    for (int p = 0; p < 2; p++) begin
      vld[p] = 0; opv[p] = 0; bszv[p] = 0; adrv[p] = 0; wdv[p] = 0;
      in_cs[p] = 0; entries[p] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check(!rdy[0] && !rdy[1], "R1 ready low", {30'd0, rdy[1], rdy[0]}, 32'd0);
    check(rdv[0] == 0 && rdv[1] == 0, "R1 rdata zero", rdv[0] | rdv[1], 32'd0);
    do_op(0, 2'd0, 1'b0, 8'h3c, 0, rd, lat);
    check(rd == 0, "R1 memory cleared", rd, 0);
    check(lat == 1, "R2 read latency", lat, 1);

    // word write, then byte exchange into lane 2, then word read back
    do_op(1, 2'd1, 1'b0, 8'h08, 32'hAABBCCDD, rd, lat);
    check(lat == 1, "R3 write latency", lat, 1);
    do_op(1, 2'd2, 1'b1, 8'h0a, 32'h00000011, rd, lat);
    check(rd == 32'h000000BB, "R6 old byte lane 2", rd, 32'h000000BB);
    check(lat == 2, "R6 exchange latency", lat, 2);
    do_op(0, 2'd0, 1'b0, 8'h08, 0, rd, lat);
    check(rd == 32'hAA11CCDD, "R6 other lanes kept", rd, 32'hAA11CCDD);
    do_op(0, 2'd1, 1'b1, 8'h0b, 32'hFFFFFF5A, rd, lat);
    do_op(0, 2'd0, 1'b0, 8'h08, 0, rd, lat);
    check(rd == 32'h5A11CCDD, "R3 byte write lane 3 only", rd, 32'h5A11CCDD);
    do_op(0, 2'd0, 1'b1, 8'h09, 0, rd, lat);
    check(rd == 32'h000000CC, "R2 byte read lane 1", rd, 32'h000000CC);
    do_op(1, 2'd2, 1'b0, 8'h08, 32'h12345678, rd, lat);
    check(rd == 32'h5A11CCDD && lat == 2, "R4 word exchange", rd, 32'h5A11CCDD);
    do_op(1, 2'd0, 1'b0, 8'h08, 0, rd, lat);
    check(rd == 32'h12345678, "R4 new value stored", rd, 32'h12345678);

    // pointer is now port 0 (last owner port 1): both at once, port 0 first
    fork
      do_op(0, 2'd2, 1'b0, 8'h10, 32'h1, rd, lat);
      do_op(1, 2'd2, 1'b0, 8'h10, 32'h2, rd1, lat1);
    join
    check(lat == 2 && lat1 > 2, "R7 pointer port 0 wins", lat, 2);
    check(rd1 == 32'h1, "R5 second exchange sees first", rd1, 32'h1);
    do_op(0, 2'd0, 1'b0, 8'h10, 0, rd, lat);
    fork
      do_op(0, 2'd0, 1'b0, 8'h10, 0, rd, lat);
      do_op(1, 2'd0, 1'b0, 8'h10, 0, rd1, lat1);
    join
    check(lat1 == 1 && lat > 1, "R7 pointer port 1 wins", lat1, 1);

    fork
      rand_port(0, 300);
      rand_port(1, 300);
    join
    for (int i = 0; i < 32; i += 4) begin
      do_op(0, 2'd0, 1'b0, 8'(i), 0, rd, lat);
    end

    do_op(0, 2'd1, 1'b0, 8'h80, 32'd0, rd, lat);
    fork
      lock_port(0, 25);
      lock_port(1, 25);
    join
    do_op(1, 2'd0, 1'b0, 8'h84, 0, rd, lat);
    check(rd == model_get(8'h84, 1'b0), "R5 guarded counter", rd, model_get(8'h84, 1'b0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule